// File: doc/BRIEF.md
# Shadow Array Save/Restore Sequencer

This block owns two synchronous memories of equal size: a working array that a host reads and writes, and a shadow array that stands in for nonvolatile storage. A save request wipes the shadow array to the erased pattern and then copies the working array into it, one word per clock. A restore request zeroes the working array and then copies the shadow array back into it, also one word per clock. After each copy phase comes a settle interval whose length is a parameter. It stands in for the long programming time of real cells.

While an operation runs, `busy` is high and the host port is shut out. Reads return no data, with the read-valid flag held low, which means the bus is undriven. Writes are discarded. A request made while `busy` is high is ignored. Each operation ends with a single-cycle `done` pulse in the cycle where `busy` falls. A restore only reads the shadow array, so the same image can be restored any number of times.

Top module: `nvs_engine`

## Requirements
- R1: After reset, `busy`, `done` and `host_rvalid` are all 0.
- R2: While idle, a host write (`host_en`=1, `host_we`=1) stores `host_wdata` at `host_addr`. A host read (`host_en`=1, `host_we`=0) returns that word on `host_rdata` with `host_rvalid`=1 in the following cycle.
- R3: A save request accepted while idle raises `busy` in the next cycle. `busy` stays high for exactly 2*2^ADDR_W + STORE_TAIL cycles. `done` is high for one cycle, in the first cycle `busy` is low.
- R4: A restore request accepted while idle keeps `busy` high for exactly 2*2^ADDR_W + RECALL_TAIL cycles and ends with the same single `done` pulse.
- R5: After a save, any later host writes, and then a restore, every word of the working array equals its value at the time of the save.
- R6: A restore leaves the shadow array unchanged. A second restore after further host writes brings back the same image again.
- R7: A host read issued while `busy` is high gives `host_rvalid`=0 in the next cycle.
- R8: A host write issued while `busy` is high has no effect on the working array.
- R9: A request made while `busy` is high is ignored. The running operation keeps its normal length, and `busy` stays low after its `done`.
- R10: If save and restore are requested in the same idle cycle, the save wins. `busy` then lasts the save length, and the shadow array receives the working array.
- R11: A host write made in the same idle cycle as a save request is performed first, so it is part of the saved image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_en | input | 1 | Host access strobe |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | ADDR_W | Host word address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Read data, zero when not valid |
| host_rvalid | output | 1 | Read data driven (output enable) |
| store_req | input | 1 | Save working array to shadow |
| recall_req | input | 1 | Restore shadow into working array |
| busy | output | 1 | Operation in progress, host locked out |
| done | output | 1 | One-cycle end-of-operation pulse |

## Verification
Two collisions can occur in one cycle: a host write with a save request, and a save request with a restore request. The bench drives each collision in a single idle cycle. A later restore then shows which image reached the shadow array. The measured busy length shows which operation ran, because the two settle lengths differ. Host writes, reads and extra requests are also injected in the middle of a busy window. They are judged by the read-valid flag and by reading the target word back after `done`.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_ERASE,
    SQ_PROG,
    SQ_SWAIT,
    SQ_CLEAR,
    SQ_XFER,
    SQ_RWAIT
  } seq_state_t;
endpackage

// File: rtl/nvs_spram.sv
module nvs_spram #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // read-first single port, inferable as block RAM
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/nvs_sequencer.sv
module nvs_sequencer
  import nvs_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int STORE_TAIL  = 12,
  parameter int RECALL_TAIL = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              store_req,
  input  logic              recall_req,
  output logic              busy,
  output logic              done,
  output logic              sram_we,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_copy,
  output logic              shd_we,
  output logic [ADDR_W-1:0] shd_addr,
  output logic              shd_copy
);
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int TAIL_MAX = (STORE_TAIL > RECALL_TAIL) ? STORE_TAIL : RECALL_TAIL;
  localparam int TAIL_W   = $clog2(TAIL_MAX + 1);
  localparam int CNT_W    = (TAIL_W > ADDR_W) ? TAIL_W : ADDR_W;

  seq_state_t        state, nxt;
  logic [CNT_W-1:0]  cnt;
  logic              word_last, stail_last, rtail_last;
  logic              pend_q, pend_to_shd_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [ADDR_W-1:0] cnt_addr;

  assign cnt_addr   = cnt[ADDR_W-1:0];
  assign word_last  = (cnt == CNT_W'(DEPTH - 1));
  assign stail_last = (cnt == CNT_W'(STORE_TAIL - 1));
  assign rtail_last = (cnt == CNT_W'(RECALL_TAIL - 1));

  always_comb begin
    nxt = state;
    unique case (state)
      SQ_IDLE:  if (store_req) nxt = SQ_ERASE;
                else if (recall_req) nxt = SQ_CLEAR;
      SQ_ERASE: if (word_last) nxt = SQ_PROG;
      SQ_PROG:  if (word_last) nxt = SQ_SWAIT;
      SQ_SWAIT: if (stail_last) nxt = SQ_IDLE;
      SQ_CLEAR: if (word_last) nxt = SQ_XFER;
      SQ_XFER:  if (word_last) nxt = SQ_RWAIT;
      SQ_RWAIT: if (rtail_last) nxt = SQ_IDLE;
      default:  nxt = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SQ_IDLE;
      cnt   <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      state <= nxt;
      cnt   <= (nxt != state) ? '0 : cnt + 1'b1;
      busy  <= (nxt != SQ_IDLE);
      done  <= (state == SQ_SWAIT && stail_last) || (state == SQ_RWAIT && rtail_last);
    end
  end

  // copy pipeline: read issued at cnt, write lands one cycle later
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q        <= 1'b0;
      pend_to_shd_q <= 1'b0;
      pend_addr_q   <= '0;
    end else begin
      pend_q        <= (state == SQ_PROG) || (state == SQ_XFER);
      pend_to_shd_q <= (state == SQ_PROG);
      pend_addr_q   <= cnt_addr;
    end
  end

  always_comb begin
    shd_we    = (state == SQ_ERASE) || (pend_q && pend_to_shd_q);
    shd_copy  = pend_q && pend_to_shd_q;
    shd_addr  = shd_copy ? pend_addr_q : cnt_addr;
    sram_copy = pend_q && !pend_to_shd_q;
    sram_we   = (state == SQ_CLEAR) || sram_copy;
    sram_addr = sram_copy ? pend_addr_q : cnt_addr;
  end
endmodule

// File: rtl/nvs_engine.sv
module nvs_engine #(
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 8,
  parameter int STORE_TAIL  = 12,
  parameter int RECALL_TAIL = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_en,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid,
  input  logic              store_req,
  input  logic              recall_req,
  output logic              busy,
  output logic              done
);
  logic              e_sram_we, e_sram_copy, e_shd_we, e_shd_copy;
  logic [ADDR_W-1:0] e_sram_addr, e_shd_addr;
  logic              w_we;
  logic [ADDR_W-1:0] w_addr;
  logic [DATA_W-1:0] w_wdata, w_rdata, s_wdata, s_rdata;
  logic              rvalid_q;

  nvs_sequencer #(
    .ADDR_W(ADDR_W), .STORE_TAIL(STORE_TAIL), .RECALL_TAIL(RECALL_TAIL)
  ) u_seq (
    .clk(clk), .rst(rst), .store_req(store_req), .recall_req(recall_req),
    .busy(busy), .done(done),
    .sram_we(e_sram_we), .sram_addr(e_sram_addr), .sram_copy(e_sram_copy),
    .shd_we(e_shd_we), .shd_addr(e_shd_addr), .shd_copy(e_shd_copy)
  );

  // working array: host owns the port while idle
  always_comb begin
    if (busy) begin
      w_we    = e_sram_we;
      w_addr  = e_sram_addr;
      w_wdata = e_sram_copy ? s_rdata : '0;
    end else begin
      w_we    = host_en && host_we;
      w_addr  = host_addr;
      w_wdata = host_wdata;
    end
  end

  assign s_wdata = e_shd_copy ? w_rdata : '1;

  nvs_spram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_work (
    .clk(clk), .we(w_we), .addr(w_addr), .wdata(w_wdata), .rdata(w_rdata)
  );

  nvs_spram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shadow (
    .clk(clk), .we(e_shd_we), .addr(e_shd_addr), .wdata(s_wdata), .rdata(s_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) rvalid_q <= 1'b0;
    else     rvalid_q <= host_en && !host_we && !busy;
  end

  assign host_rvalid = rvalid_q;
  assign host_rdata  = rvalid_q ? w_rdata : '0;
endmodule

// File: rtl/nvs_engine_chk.sv
module nvs_engine_chk (
  input logic clk,
  input logic rst,
  input logic host_en,
  input logic host_we,
  input logic host_rvalid,
  input logic store_req,
  input logic recall_req,
  input logic busy,
  input logic done
);
  assert_read_hidden_R7: assert property (@(posedge clk) disable iff (rst)
    busy |=> !host_rvalid);

  assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_at_end_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> $fell(busy));

  assert_end_has_done_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  assert_start_needs_req_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(store_req || recall_req));

  assert_idle_read_served_R2: assert property (@(posedge clk) disable iff (rst)
    (host_en && !host_we && !busy) |=> host_rvalid);
endmodule

bind nvs_engine nvs_engine_chk u_chk (
  .clk(clk), .rst(rst), .host_en(host_en), .host_we(host_we),
  .host_rvalid(host_rvalid), .store_req(store_req), .recall_req(recall_req),
  .busy(busy), .done(done)
);

// File: tb/nvs_engine_bench.sv
module nvs_engine_bench;
  localparam int CLK_PERIOD  = 10;
  localparam int ADDR_W      = 5;
  localparam int DATA_W      = 8;
  localparam int STORE_TAIL  = 12;
  localparam int RECALL_TAIL = 4;
  localparam int DEPTH       = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_en = 1'b0, host_we = 1'b0;
  logic [ADDR_W-1:0] host_addr = '0;
  logic [DATA_W-1:0] host_wdata = '0;
  logic [DATA_W-1:0] host_rdata;
  logic host_rvalid, busy, done;
  logic store_req = 1'b0, recall_req = 1'b0;

  int n_chk = 0, n_bad = 0;
  logic [DATA_W-1:0] ref_w [DEPTH];
  logic [DATA_W-1:0] ref_s [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  nvs_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STORE_TAIL(STORE_TAIL),
               .RECALL_TAIL(RECALL_TAIL)) u_nvs_engine (
    .clk(clk), .rst(rst), .host_en(host_en), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .store_req(store_req), .recall_req(recall_req),
    .busy(busy), .done(done)
  );

  function automatic int op_len(input logic is_store);
    return 2 * DEPTH + (is_store ? STORE_TAIL : RECALL_TAIL);
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    host_en = 1; host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_en = 0; host_we = 0;
    ref_w[a] = d;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input string tag);
    @(negedge clk);
    host_en = 1; host_we = 0; host_addr = a;
    @(negedge clk);
    host_en = 0;
    chk(host_rvalid === 1'b1, {tag, " rvalid"}, int'(host_rvalid), 1);
    chk(host_rdata === ref_w[a], tag, int'(host_rdata), int'(ref_w[a]));
  endtask

  // mode: 0 none, 1 write while busy, 2 read while busy, 3 request while busy
  task automatic op(input logic s, input logic r, input logic w_same,
                    input logic [ADDR_W-1:0] wa, input logic [DATA_W-1:0] wd,
                    input int mode, input int exp_len, input string tag);
    int cnt;
    @(negedge clk);
    store_req = s; recall_req = r;
    if (w_same) begin host_en = 1; host_we = 1; host_addr = wa; host_wdata = wd; ref_w[wa] = wd; end
    @(negedge clk);
    store_req = 0; recall_req = 0; host_en = 0; host_we = 0;
    cnt = 0;
    while (busy === 1'b1 && cnt < 10000) begin
      cnt++;
      if (cnt == 3) begin
        case (mode)
          1: begin host_en = 1; host_we = 1; host_addr = wa; host_wdata = ~ref_w[wa]; end
          2: begin host_en = 1; host_we = 0; host_addr = wa; end
          3: begin store_req = 1; recall_req = 1; end
          default: ;
        endcase
      end
      if (cnt == 4) begin
        if (mode == 2) chk(host_rvalid === 1'b0, "R7 read during busy", int'(host_rvalid), 0);
        host_en = 0; host_we = 0; store_req = 0; recall_req = 0;
      end
      @(negedge clk);
    end
    chk(cnt == exp_len, {tag, " busy length"}, cnt, exp_len);
    chk(done === 1'b1, {tag, " done pulse"}, int'(done), 1);
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, {tag, " R9 quiet after done"}, int'({busy, done}), 0);
    if (s) begin for (int i = 0; i < DEPTH; i++) ref_s[i] = ref_w[i]; end
    else if (r) begin for (int i = 0; i < DEPTH; i++) ref_w[i] = ref_s[i]; end
  endtask

  task automatic scramble();
    for (int i = 0; i < DEPTH; i++) wr(ADDR_W'(i), DATA_W'($urandom));
  endtask

  task automatic read_all(input string tag);
    for (int i = 0; i < DEPTH; i++) rd(ADDR_W'(i), tag);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int seed_sink;
    seed_sink = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(busy === 1'b0 && done === 1'b0 && host_rvalid === 1'b0, "R1 reset",
        int'({busy, done, host_rvalid}), 0);

    // R2 basic access
    scramble();
    rd(ADDR_W'(0), "R2 read");
    rd(ADDR_W'(DEPTH-1), "R2 read top");

    // R3 save, R5 restore after overwrite
    op(1, 0, 0, '0, '0, 0, op_len(1), "R3 save");
    scramble();
    rd(ADDR_W'(7), "R2 post-save write");
    op(0, 1, 0, '0, '0, 0, op_len(0), "R4 restore");
    read_all("R5 restored image");

    // R6 repeated restore, shadow untouched
    scramble();
    op(0, 1, 0, '0, '0, 0, op_len(0), "R6 restore again");
    read_all("R6 second restore");

    // R8 write during busy dropped
    op(1, 0, 0, ADDR_W'(5), '0, 1, op_len(1), "R8 save with write");
    rd(ADDR_W'(5), "R8 dropped write");
    // R7 read during busy
    op(0, 1, 0, ADDR_W'(9), '0, 2, op_len(0), "R7 restore with read");
    // R9 request during busy
    op(0, 1, 0, '0, '0, 3, op_len(0), "R9 restore with request");
    rd(ADDR_W'(3), "R9 data intact");

    // R10 simultaneous requests: save wins
    scramble();
    op(1, 1, 0, '0, '0, 0, op_len(1), "R10 both requests");
    scramble();
    op(0, 1, 0, '0, '0, 0, op_len(0), "R10 follow restore");
    read_all("R10 saved image");

    // R11 write in request cycle
    op(1, 0, 1, ADDR_W'(DEPTH-1), 8'hA5, 0, op_len(1), "R11 save with write");
    wr(ADDR_W'(DEPTH-1), 8'h3C);
    op(0, 1, 0, '0, '0, 0, op_len(0), "R11 restore");
    rd(ADDR_W'(DEPTH-1), "R11 same-cycle write saved");

    // random mix
    for (int k = 0; k < 300; k++) begin
      int sel;
      sel = int'($urandom % 20);
      if (sel < 9) wr(ADDR_W'($urandom), DATA_W'($urandom));
      else if (sel < 18) rd(ADDR_W'($urandom), "R2 random read");
      else if (sel == 18) op(1, 0, 0, '0, '0, 0, op_len(1), "R3 random save");
      else op(0, 1, 0, '0, '0, 0, op_len(0), "R5 random restore");
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule